// File: doc/BRIEF.md
# Attribute Controller Register Port

This block sits between the host register bus of a planar video adapter and its pixel path. The host reaches all of its registers through a single write port whose role flips on every write: one write selects a register, the next write stores data into it. An internal toggle records which role comes next. A read of the input status port returns the toggle to selection mode, so software can always resynchronise. A separate read port combinationally returns the register named by the current selection.

Inside are sixteen 6-bit palette entries plus five control registers:
- mode control (index 10h)
- border colour (11h)
- plane enable (12h)
- horizontal pan (13h)
- colour select (14h)

On the pixel side, a 4-bit pixel value is gated plane by plane, looked up in the palette and widened to an 8-bit colour-table index. The upper bits of that index come from the palette or the colour select register, according to the mode. During the border region, or while the screen-enable bit of the selection write is clear, the border colour is output instead. Two bits of the produced index are mirrored to a status pair for diagnostics. The pan amount is passed to the downstream serializer.

Top module: `attr_ctrl_port`

## Requirements
- R1: While `rst` is high and on the cycle after it, `color_idx`, `stat_bits`, `pan_shift` and `host_rdata` are zero; the selection is 0, screen enable is clear, and the toggle is in selection mode.
- R2: With the toggle in selection mode, a write stores `host_wdata[4:0]` as the selection and `host_wdata[5]` as screen enable, then moves the toggle to data mode. In data mode, a write targets the selected register, leaves the selection unchanged and returns the toggle to selection mode.
- R3: A cycle with `status_rd` high leaves the toggle in selection mode for the next write. This holds even when a write in the same cycle is processed according to the old toggle state.
- R4: `host_rdata` returns the selected register, zero-extended: palette 6 bits, mode 8 bits, border 6 bits, plane enable 6 bits, pan 4 bits, colour select 4 bits. Selections 15h-1Fh read as 0, and data writes to them change nothing.
- R5: A data write to selections 00h-0Fh is ignored while screen enable is set. Registers 10h-14h accept writes whatever screen enable is.
- R6: Plane enable bits 0-3 AND the four pixel bits before the palette lookup.
- R7: `color_idx[3:0]` is palette bits 3:0. When mode bit 6 is clear, `color_idx[5:4]` is colour select bits 1:0 if mode bit 7 is set, and palette bits 5:4 otherwise.
- R8: When mode bit 6 is clear, `color_idx[7:6]` is colour select bits 3:2. When mode bit 6 is set, colour select has no effect: bits 5:4 come from the palette and bits 7:6 are 0.
- R9: When `border` is high or screen enable is clear, `color_idx` is the border colour zero-extended to 8 bits.
- R10: `stat_bits` = {hi, lo} taken from `color_idx`, chosen by plane enable bits 5:4. The choices are 0 → bits 2/0, 1 → bits 5/4, 2 → bits 3/1, 3 → bits 7/6.
- R11: `color_idx` reflects `pix_in` and `border` sampled at the previous rising clock edge (one register stage).
- R12: `pan_shift` always equals the stored pan register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Write strobe for the shared selection/data port |
| host_wdata | input | 8 | Write data |
| status_rd | input | 1 | Input status read strobe; returns the toggle to selection mode |
| host_rdata | output | 8 | Contents of the selected register |
| pix_in | input | 4 | Incoming pixel plane bits |
| border | input | 1 | High during the border region |
| color_idx | output | 8 | Colour-table index, one cycle after the pixel |
| stat_bits | output | 2 | Two mirrored bits of `color_idx` |
| pan_shift | output | 4 | Horizontal pan amount for the serializer |

## Verification
The assertions take for granted that every strobe is sampled cleanly at the rising edge, and that no write arrives while reset is high. The palette-lock property also relies on the selection being altered only by a write in selection mode. The bench therefore drives all inputs on falling edges and keeps `host_wr` low during reset. It opens each register access with a status read, so its model of the toggle never drifts from the design. The single directed case that overlaps a write with a status read is modelled cycle by cycle.

// File: rtl/attr_pkg.sv
package attr_pkg;
    localparam int PIX_W  = 4;
    localparam int NUM_PAL = 1 << PIX_W;
    localparam int PAL_W  = 6;
    localparam int SEL_W  = 5;
    localparam int DAT_W  = 8;
    localparam int OUT_W  = 8;
    localparam int CSEL_W = 4;
    localparam int PAN_W  = 4;
    localparam int MODE_W = 8;

    localparam logic [SEL_W-1:0] IX_MODE  = 5'h10;
    localparam logic [SEL_W-1:0] IX_BORD  = 5'h11;
    localparam logic [SEL_W-1:0] IX_PLANE = 5'h12;
    localparam logic [SEL_W-1:0] IX_PAN   = 5'h13;
    localparam logic [SEL_W-1:0] IX_CSEL  = 5'h14;

    localparam int MB_WIDE   = 6;  // 256-colour: colour select ignored
    localparam int MB_MIDSRC = 7;  // index bits 5:4 from colour select

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [PAL_W-1:0]  bord;
        logic [PAL_W-1:0]  plane;
        logic [PAN_W-1:0]  pan;
        logic [CSEL_W-1:0] csel;
    } ctl_regs_t;

    typedef struct packed {
        logic             wr;
        logic             pal_lock;
        logic [SEL_W-1:0] sel;
        logic [DAT_W-1:0] data;
    } reg_wr_t;

    function automatic logic [OUT_W-1:0] compose_index(
        input logic [PAL_W-1:0]  ent,
        input logic [MODE_W-1:0] mode,
        input logic [CSEL_W-1:0] csel
    );
        logic [OUT_W-1:0] r;
        r      = '0;
        r[3:0] = ent[3:0];
        if (mode[MB_WIDE]) begin
            r[5:4] = ent[5:4];
        end else begin
            r[5:4] = mode[MB_MIDSRC] ? csel[1:0] : ent[5:4];
            r[7:6] = csel[3:2];
        end
        return r;
    endfunction

    function automatic logic [1:0] status_pick(
        input logic [OUT_W-1:0] c,
        input logic [1:0]       sel
    );
        case (sel)
            2'd0:    return {c[2], c[0]};
            2'd1:    return {c[5], c[4]};
            2'd2:    return {c[3], c[1]};
            default: return {c[7], c[6]};
        endcase
    endfunction
endpackage

// File: rtl/attr_host_if.sv
module attr_host_if
    import attr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             host_wr,
    input  logic [DAT_W-1:0] host_wdata,
    input  logic             status_rd,
    output logic             data_phase,
    output logic [SEL_W-1:0] cur_sel,
    output logic             scr_on,
    output reg_wr_t          wr_req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_phase <= 1'b0;
            cur_sel    <= '0;
            scr_on     <= 1'b0;
        end else begin
            if (host_wr) begin
                if (!data_phase) begin
                    cur_sel    <= host_wdata[SEL_W-1:0];
                    scr_on     <= host_wdata[SEL_W];
                    data_phase <= 1'b1;
                end else begin
                    data_phase <= 1'b0;
                end
            end
            if (status_rd) data_phase <= 1'b0;
        end
    end

    always_comb begin
        wr_req.wr       = host_wr && data_phase;
        wr_req.pal_lock = scr_on;
        wr_req.sel      = cur_sel;
        wr_req.data     = host_wdata;
    end
endmodule

// File: rtl/attr_regfile.sv
module attr_regfile
    import attr_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  reg_wr_t                         wr_req,
    input  logic [SEL_W-1:0]                rd_sel,
    output logic [NUM_PAL-1:0][PAL_W-1:0]   pal_q,
    output ctl_regs_t                       ctl_q,
    output logic [DAT_W-1:0]                rdata
);
    logic [NUM_PAL-1:0] pal_hit;

    for (genvar i = 0; i < NUM_PAL; i++) begin : g_hit
        assign pal_hit[i] = wr_req.wr && !wr_req.pal_lock
                            && (wr_req.sel == SEL_W'(i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pal_q <= '0;
        end else begin
            for (int k = 0; k < NUM_PAL; k++) begin
                if (pal_hit[k]) pal_q[k] <= wr_req.data[PAL_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (wr_req.wr) begin
            case (wr_req.sel)
                IX_MODE:  ctl_q.mode  <= wr_req.data[MODE_W-1:0];
                IX_BORD:  ctl_q.bord  <= wr_req.data[PAL_W-1:0];
                IX_PLANE: ctl_q.plane <= wr_req.data[PAL_W-1:0];
                IX_PAN:   ctl_q.pan   <= wr_req.data[PAN_W-1:0];
                IX_CSEL:  ctl_q.csel  <= wr_req.data[CSEL_W-1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_sel < SEL_W'(NUM_PAL)) begin
            rdata = DAT_W'(pal_q[rd_sel[PIX_W-1:0]]);
        end else begin
            case (rd_sel)
                IX_MODE:  rdata = DAT_W'(ctl_q.mode);
                IX_BORD:  rdata = DAT_W'(ctl_q.bord);
                IX_PLANE: rdata = DAT_W'(ctl_q.plane);
                IX_PAN:   rdata = DAT_W'(ctl_q.pan);
                IX_CSEL:  rdata = DAT_W'(ctl_q.csel);
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/attr_pix_map.sv
module attr_pix_map
    import attr_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [PIX_W-1:0]              pix_in,
    input  logic                          border,
    input  logic                          scr_on,
    input  logic [NUM_PAL-1:0][PAL_W-1:0] pal_q,
    input  ctl_regs_t                     ctl_q,
    output logic [OUT_W-1:0]              color_idx,
    output logic [1:0]                    stat_bits
);
    logic [PIX_W-1:0] gated;
    logic [PAL_W-1:0] entry;
    logic [OUT_W-1:0] idx_nxt;

    always_comb begin
        gated = pix_in & ctl_q.plane[PIX_W-1:0];
        entry = pal_q[gated];
        if (border || !scr_on) idx_nxt = OUT_W'(ctl_q.bord);
        else                   idx_nxt = compose_index(entry, ctl_q.mode, ctl_q.csel);
    end

    always_ff @(posedge clk) begin
        if (rst) color_idx <= '0;
        else     color_idx <= idx_nxt;
    end

    assign stat_bits = rst ? 2'b00 : status_pick(color_idx, ctl_q.plane[PAL_W-1:PIX_W]);
endmodule

// File: rtl/attr_ctrl_port.sv
module attr_ctrl_port
    import attr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             host_wr,
    input  logic [DAT_W-1:0] host_wdata,
    input  logic             status_rd,
    output logic [DAT_W-1:0] host_rdata,
    input  logic [PIX_W-1:0] pix_in,
    input  logic             border,
    output logic [OUT_W-1:0] color_idx,
    output logic [1:0]       stat_bits,
    output logic [PAN_W-1:0] pan_shift
);
    logic                          data_phase;
    logic [SEL_W-1:0]              cur_sel;
    logic                          scr_on;
    reg_wr_t                       wr_req;
    logic [NUM_PAL-1:0][PAL_W-1:0] pal_q;
    ctl_regs_t                     ctl_q;

    attr_host_if u_host (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
        .status_rd(status_rd), .data_phase(data_phase), .cur_sel(cur_sel),
        .scr_on(scr_on), .wr_req(wr_req)
    );

    attr_regfile u_regs (
        .clk(clk), .rst(rst), .wr_req(wr_req), .rd_sel(cur_sel),
        .pal_q(pal_q), .ctl_q(ctl_q), .rdata(host_rdata)
    );

    attr_pix_map u_pix (
        .clk(clk), .rst(rst), .pix_in(pix_in), .border(border),
        .scr_on(scr_on), .pal_q(pal_q), .ctl_q(ctl_q),
        .color_idx(color_idx), .stat_bits(stat_bits)
    );

    assign pan_shift = ctl_q.pan;
endmodule

// File: rtl/attr_ctrl_port_chk.sv
module attr_ctrl_port_chk
    import attr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             host_wr,
    input logic             status_rd,
    input logic             border,
    input logic             data_phase,
    input logic [SEL_W-1:0] cur_sel,
    input logic             scr_on,
    input logic [DAT_W-1:0] host_rdata,
    input logic [OUT_W-1:0] color_idx,
    input logic [PAN_W-1:0] pan_shift
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (color_idx == '0 && host_rdata == '0 && !data_phase)); // R1

    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !status_rd) |=> (data_phase != $past(data_phase))); // R2

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (host_wr && data_phase) |=> $stable(cur_sel)); // R2

    AST_STATUS_ADDR: assert property (@(posedge clk) disable iff (rst)
        status_rd |=> !data_phase); // R3

    AST_PAL_LOCK: assert property (@(posedge clk) disable iff (rst)
        (host_wr && data_phase && scr_on && cur_sel < SEL_W'(NUM_PAL))
        |=> $stable(host_rdata)); // R5

    AST_BORDER_HIGH: assert property (@(posedge clk) disable iff (rst)
        (border || !scr_on) |=> (color_idx[OUT_W-1:PAL_W] == '0)); // R9

    AST_PAN_MATCH: assert property (@(posedge clk) disable iff (rst)
        (cur_sel == IX_PAN) |-> (host_rdata == DAT_W'(pan_shift))); // R12
endmodule

bind attr_ctrl_port attr_ctrl_port_chk u_chk (
    .clk(clk), .rst(rst), .host_wr(host_wr), .status_rd(status_rd),
    .border(border), .data_phase(data_phase), .cur_sel(cur_sel),
    .scr_on(scr_on), .host_rdata(host_rdata), .color_idx(color_idx),
    .pan_shift(pan_shift)
);

// File: tb/attr_ctrl_port_tb.sv
module attr_ctrl_port_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic       status_rd = 1'b0;
    logic [7:0] host_rdata;
    logic [3:0] pix_in = '0;
    logic       border = 1'b0;
    logic [7:0] color_idx;
    logic [1:0] stat_bits;
    logic [3:0] pan_shift;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    attr_ctrl_port u_dut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
        .status_rd(status_rd), .host_rdata(host_rdata), .pix_in(pix_in),
        .border(border), .color_idx(color_idx), .stat_bits(stat_bits),
        .pan_shift(pan_shift)
    );

    // reference model state
    logic [5:0] m_pal [16];
    logic [7:0] m_mode;
    logic [5:0] m_bord, m_plane;
    logic [3:0] m_pan, m_csel;
    logic [4:0] m_sel;
    logic       m_en;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] m_idx(input logic [3:0] p, input logic brd);
        logic [7:0] r;
        logic [5:0] e;
        if (brd || !m_en) return {2'b00, m_bord};
        e = m_pal[p & m_plane[3:0]];
        r = {4'h0, e[3:0]};
        if (m_mode[6]) r[5:4] = e[5:4];
        else begin
            r[5:4] = m_mode[7] ? m_csel[1:0] : e[5:4];
            r[7:6] = m_csel[3:2];
        end
        return r;
    endfunction

    function automatic logic [1:0] m_stat(input logic [7:0] c);
        case (m_plane[5:4])
            2'd0: return {c[2], c[0]};
            2'd1: return {c[5], c[4]};
            2'd2: return {c[3], c[1]};
            default: return {c[7], c[6]};
        endcase
    endfunction

    function automatic logic [7:0] m_rd(input logic [4:0] s);
        if (s < 5'h10) return {2'b00, m_pal[s[3:0]]};
        case (s)
            5'h10: return m_mode;
            5'h11: return {2'b00, m_bord};
            5'h12: return {2'b00, m_plane};
            5'h13: return {4'h0, m_pan};
            5'h14: return {4'h0, m_csel};
            default: return 8'h00;
        endcase
    endfunction

    task automatic drive_wr(input logic [7:0] b);
        @(negedge clk); host_wr = 1'b1; host_wdata = b;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic stat_read();
        @(negedge clk); status_rd = 1'b1;
        @(negedge clk); status_rd = 1'b0;
    endtask

    task automatic model_data(input logic [7:0] v);
        if (m_sel < 5'h10) begin
            if (!m_en) m_pal[m_sel[3:0]] = v[5:0];
        end else case (m_sel)
            5'h10: m_mode  = v;
            5'h11: m_bord  = v[5:0];
            5'h12: m_plane = v[5:0];
            5'h13: m_pan   = v[3:0];
            5'h14: m_csel  = v[3:0];
            default: ;
        endcase
    endtask

    task automatic set_reg(input logic [4:0] s, input logic [7:0] v, input logic en);
        stat_read();
        drive_wr({2'b00, en, s});
        m_sel = s; m_en = en;
        drive_wr(v);
        model_data(v);
    endtask

    task automatic pix(input logic [3:0] p, input logic brd, input string req);
        logic [7:0] e;
        @(negedge clk); pix_in = p; border = brd;
        e = m_idx(p, brd);
        @(negedge clk);
        check(req, color_idx, e);
        check("R10", {6'b0, stat_bits}, {6'b0, m_stat(e)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'hA77C));
        for (int i = 0; i < 16; i++) m_pal[i] = '0;
        m_mode = '0; m_bord = '0; m_plane = '0; m_pan = '0; m_csel = '0;
        m_sel = '0; m_en = 1'b0;
        repeat (3) @(negedge clk);
        // R1 during and just after reset
        check("R1", color_idx, 8'h00);
        check("R1", host_rdata, 8'h00);
        @(negedge clk); rst = 1'b0;
        check("R1", {4'h0, pan_shift}, 8'h00);
        check("R1", {6'b0, stat_bits}, 8'h00);

        // R2/R4 writes and readback
        set_reg(5'h10, 8'hA5, 1'b0); check("R4 mode", host_rdata, 8'hA5);
        set_reg(5'h11, 8'hFF, 1'b0); check("R4 bord", host_rdata, 8'h3F);
        set_reg(5'h14, 8'hFE, 1'b0); check("R4 csel", host_rdata, 8'h0E);
        set_reg(5'h07, 8'hEA, 1'b0); check("R2 pal", host_rdata, 8'h2A);
        set_reg(5'h17, 8'hFF, 1'b0); check("R4 unused", host_rdata, 8'h00);
        set_reg(5'h1F, 8'h55, 1'b0); check("R4 unused", host_rdata, 8'h00);

        // R5 palette lock, control still writable
        set_reg(5'h07, 8'h11, 1'b1); check("R5 locked", host_rdata, 8'h2A);
        set_reg(5'h12, 8'h0F, 1'b1); check("R5 ctl", host_rdata, 8'h0F);

        // R3 status read returns to selection mode mid-sequence
        stat_read();
        drive_wr(8'h11); m_sel = 5'h11; m_en = 1'b0;
        stat_read();
        drive_wr(8'h13); m_sel = 5'h13;
        drive_wr(8'h05); model_data(8'h05);
        check("R3 pan", {4'h0, pan_shift}, 8'h05);
        check("R12", host_rdata, 8'h05);
        stat_read(); drive_wr(8'h11);
        check("R3 bord kept", host_rdata, {2'b00, m_bord});

        // R3 write and status read in the same cycle
        stat_read();
        @(negedge clk); host_wr = 1'b1; host_wdata = 8'h34; status_rd = 1'b1;
        @(negedge clk); host_wr = 1'b0; status_rd = 1'b0;
        m_sel = 5'h14; m_en = 1'b1;
        drive_wr(8'h33); m_sel = 5'h13;
        drive_wr(8'h07); model_data(8'h07);
        check("R3 overlap", {4'h0, pan_shift}, 8'h07);
        stat_read(); drive_wr(8'h34);
        check("R3 csel kept", host_rdata, {4'h0, m_csel});

        // palette fill and pixel mapping
        for (int i = 0; i < 16; i++) set_reg(5'(i), 8'((i * 7 + 3) & 63), 1'b0);
        set_reg(5'h14, 8'h09, 1'b1);
        set_reg(5'h10, 8'h00, 1'b1);
        set_reg(5'h12, 8'h0F, 1'b1);
        pix(4'h5, 1'b0, "R7");
        pix(4'hB, 1'b0, "R11");
        set_reg(5'h10, 8'h80, 1'b1); pix(4'h9, 1'b0, "R7 mid");
        set_reg(5'h10, 8'hC0, 1'b1); pix(4'h9, 1'b0, "R8 wide");
        set_reg(5'h10, 8'h00, 1'b1); pix(4'hE, 1'b0, "R8");
        set_reg(5'h12, 8'h05, 1'b1); pix(4'hF, 1'b0, "R6");
        set_reg(5'h12, 8'h00, 1'b1); pix(4'hF, 1'b0, "R6 off");
        set_reg(5'h11, 8'h2D, 1'b1); pix(4'h3, 1'b1, "R9 border");
        set_reg(5'h12, 8'h0F, 1'b0); pix(4'h3, 1'b0, "R9 blank");
        for (int s = 0; s < 4; s++) begin
            set_reg(5'h12, 8'({s[1:0], 4'hF}), 1'b1);
            pix(4'hD, 1'b0, "R10 sel");
        end

        // constrained random
        for (int it = 0; it < 400; it++) begin
            if ($urandom_range(2) == 0) begin
                logic [4:0] s;
                s = 5'($urandom_range(22));
                set_reg(s, 8'($urandom), 1'($urandom_range(1)));
                check("R4 rand", host_rdata, m_rd(m_sel));
                check("R12 rand", {4'h0, pan_shift}, {4'h0, m_pan});
            end else begin
                if (!m_en && $urandom_range(1) == 1) set_reg(5'h13, 8'($urandom), 1'b1);
                pix(4'($urandom), ($urandom_range(5) == 0), "R7 rand");
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule